// File: doc/BRIEF.md
# Acknowledged Packet Transaction Sequencer

This block is the control state machine that carries a radio link through one complete acknowledged exchange without help from the host. In a send transaction, a go pulse brings up the oscillator and then the synthesizer, each of which must report ready. The block then runs the framer on the buffered packet and turns the radio around to listen. It waits, for a bounded time, for an acknowledgement whose echoed CRC matches the packet it just sent. In a receive transaction it brings up the same clocks and listens for a valid packet. When one arrives it raises a host interrupt, sends an acknowledgement carrying that packet's CRC, and settles in a programmable end state.

The end state is chosen by a 2-bit selector. The lower three settings park the radio at a power level: everything off, oscillator only, or oscillator plus synthesizer. The fourth setting returns to receive and waits for the next packet, so a listening node can stay armed with no host action. Outcomes are reported as one-cycle pulses: acknowledged, ACK timeout, settle failure, and packet received.

Top module: `ack_txn_seq`

## Requirements
- R1: After reset the radio is asleep: osc_en, syn_en, tx_en, rx_en, frm_start, busy and all four status pulses are low.
- R2: A tx_go pulse while not busy raises osc_en, waits for osc_rdy, then raises syn_en and waits for syn_rdy, then raises tx_en with frm_start high for exactly its first cycle and frm_is_ack low; with both ready inputs already high, tx_en is first seen 3 cycles after the go pulse.
- R3: If the awaited ready input stays low for settle_limit+1 cycles of a start-up wait, settle_err pulses for one cycle and the block goes to sleep (all enables low).
- R4: After frm_done the block listens (rx_en high); an ack_seen whose ack_crc equals the tx_crc presented with frm_done is accepted in any of the first ack_limit+1 listening cycles and gives a done_ack pulse in the next cycle.
- R5: An acknowledgement with a different CRC is ignored; with no matching acknowledgement, tmo_err pulses after exactly ack_limit+1 listening cycles.
- R6: Every transaction ends in the state picked by end_sel: 0 = sleep (all off), 1 = idle (osc_en only), 2 = synthesizer on (osc_en and syn_en), 3 = receive (osc_en, syn_en, rx_en, busy).
- R7: An rx_go pulse runs the same start-up and then listens; a pkt_valid gives, one cycle later, an rx_irq pulse together with tx_en, frm_is_ack high, frm_start high and ack_crc_out equal to that packet's pkt_crc.
- R8: frm_done during the acknowledgement send moves to the end state; with end_sel 3 the block is listening again for the next packet.
- R9: tx_go and rx_go have no effect while busy is high.
- R10: tx_en and rx_en are never high together, syn_en never without osc_en, and at most one of done_ack, tmo_err, settle_err is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_go | input | 1 | Start a send transaction |
| rx_go | input | 1 | Start a receive transaction |
| end_sel | input | 2 | End state: 0 sleep, 1 idle, 2 synth on, 3 receive |
| settle_limit | input | CW | Start-up wait limit in cycles, minus one |
| ack_limit | input | CW | ACK wait limit in cycles, minus one |
| osc_rdy | input | 1 | Oscillator stable |
| syn_rdy | input | 1 | Synthesizer locked |
| frm_done | input | 1 | Framer finished sending |
| tx_crc | input | CRCW | CRC of the packet sent, valid with frm_done |
| pkt_valid | input | 1 | Valid packet received |
| pkt_crc | input | CRCW | CRC of the received packet |
| ack_seen | input | 1 | Acknowledgement frame detected |
| ack_crc | input | CRCW | CRC echoed in the acknowledgement |
| osc_en | output | 1 | Oscillator enable |
| syn_en | output | 1 | Synthesizer enable |
| tx_en | output | 1 | Transmitter on |
| rx_en | output | 1 | Receiver on |
| frm_start | output | 1 | Framer start pulse |
| frm_is_ack | output | 1 | Framer sends an acknowledgement frame |
| ack_crc_out | output | CRCW | CRC to echo in the acknowledgement |
| busy | output | 1 | Transaction in progress |
| done_ack | output | 1 | Send acknowledged (pulse) |
| tmo_err | output | 1 | ACK wait expired (pulse) |
| settle_err | output | 1 | Start-up wait expired (pulse) |
| rx_irq | output | 1 | Packet received (pulse) |

## Verification
The hardest cases to reach are the edges of the ACK window: an acknowledgement in the last accepted cycle, one a single cycle late, and a mismatching CRC that must be ignored until the timeout. The vector table drives the acknowledgement at a chosen count of listening cycles after frm_done, with a flag that corrupts the echoed CRC, and checks which pulse arrives and in which cycle. The receive end state keeps the block busy and so locks out go pulses. After each such vector the bench completes one receive exchange with a different end state to get the block back to rest.

// File: rtl/ack_txn_seq.sv
module ack_txn_seq #(
  parameter int CW   = 16,
  parameter int CRCW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_go,
  input  logic            rx_go,
  input  logic [1:0]      end_sel,
  input  logic [CW-1:0]   settle_limit,
  input  logic [CW-1:0]   ack_limit,
  input  logic            osc_rdy,
  input  logic            syn_rdy,
  input  logic            frm_done,
  input  logic [CRCW-1:0] tx_crc,
  input  logic            pkt_valid,
  input  logic [CRCW-1:0] pkt_crc,
  input  logic            ack_seen,
  input  logic [CRCW-1:0] ack_crc,
  output logic            osc_en,
  output logic            syn_en,
  output logic            tx_en,
  output logic            rx_en,
  output logic            frm_start,
  output logic            frm_is_ack,
  output logic [CRCW-1:0] ack_crc_out,
  output logic            busy,
  output logic            done_ack,
  output logic            tmo_err,
  output logic            settle_err,
  output logic            rx_irq
);
  typedef enum logic [3:0] {
    S_SLEEP, S_IDLE, S_SYNON, S_OSC, S_SYN, S_TX, S_AWAIT, S_RX, S_ASEND
  } st_t;

  st_t st, nx;
  logic [CW-1:0]   cnt;
  logic [CRCW-1:0] crc_q;
  logic            is_tx;

  function automatic st_t end_of(input logic [1:0] s);
    case (s)
      2'd0:    return S_SLEEP;
      2'd1:    return S_IDLE;
      2'd2:    return S_SYNON;
      default: return S_RX;
    endcase
  endfunction

  wire at_rest   = (st == S_SLEEP) || (st == S_IDLE) || (st == S_SYNON);
  wire ack_hit   = ack_seen && (ack_crc == crc_q);
  wire settle_to = cnt == settle_limit;
  wire ack_to    = cnt == ack_limit;
  wire rdy_miss  = ((st == S_OSC) && !osc_rdy) || ((st == S_SYN) && !syn_rdy);

  always_comb begin
    nx = st;
    case (st)
      S_SLEEP, S_IDLE, S_SYNON: if (tx_go || rx_go) nx = S_OSC;
      S_OSC:   if (osc_rdy) nx = S_SYN; else if (settle_to) nx = S_SLEEP;
      S_SYN:   if (syn_rdy) nx = is_tx ? S_TX : S_RX; else if (settle_to) nx = S_SLEEP;
      S_TX:    if (frm_done) nx = S_AWAIT;
      S_AWAIT: if (ack_hit || ack_to) nx = end_of(end_sel);
      S_RX:    if (pkt_valid) nx = S_ASEND;
      S_ASEND: if (frm_done) nx = end_of(end_sel);
      default: nx = S_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_SLEEP;
      cnt        <= '0;
      crc_q      <= '0;
      is_tx      <= 1'b0;
      done_ack   <= 1'b0;
      tmo_err    <= 1'b0;
      settle_err <= 1'b0;
      rx_irq     <= 1'b0;
    end else begin
      st <= nx;
      if (nx != st)      cnt <= '0;
      else if (~&cnt)    cnt <= cnt + 1'b1;
      if (at_rest && (tx_go || rx_go)) is_tx <= tx_go;
      if (st == S_TX && frm_done)      crc_q <= tx_crc;
      if (st == S_RX && pkt_valid)     crc_q <= pkt_crc;
      done_ack   <= (st == S_AWAIT) && ack_hit;
      tmo_err    <= (st == S_AWAIT) && !ack_hit && ack_to;
      settle_err <= rdy_miss && settle_to;
      rx_irq     <= (st == S_RX) && pkt_valid;
    end
  end

  assign osc_en      = st != S_SLEEP;
  assign syn_en      = !(st == S_SLEEP || st == S_IDLE || st == S_OSC);
  assign tx_en       = (st == S_TX) || (st == S_ASEND);
  assign rx_en       = (st == S_AWAIT) || (st == S_RX);
  assign frm_start   = tx_en && (cnt == '0);
  assign frm_is_ack  = st == S_ASEND;
  assign ack_crc_out = crc_q;
  assign busy        = !at_rest;
endmodule

module ack_txn_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic osc_en,
  input logic syn_en,
  input logic tx_en,
  input logic rx_en,
  input logic frm_start,
  input logic frm_is_ack,
  input logic busy,
  input logic done_ack,
  input logic tmo_err,
  input logic settle_err,
  input logic rx_irq
);
  AST_TXRX_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(tx_en && rx_en)); // R10
  AST_SYN_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n) syn_en |-> osc_en); // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({done_ack, tmo_err, settle_err})); // R10
  AST_START_WHEN_TX: assert property (@(posedge clk) disable iff (!rst_n) frm_start |-> tx_en); // R2
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) frm_start |=> !frm_start); // R2
  AST_DONE_AFTER_LISTEN: assert property (@(posedge clk) disable iff (!rst_n) done_ack |-> $past(rx_en)); // R4
  AST_TMO_AFTER_LISTEN: assert property (@(posedge clk) disable iff (!rst_n) tmo_err |-> $past(rx_en)); // R5
  AST_SETTLE_SLEEP: assert property (@(posedge clk) disable iff (!rst_n) settle_err |-> !osc_en && !busy); // R3
  AST_IRQ_SENDS_ACK: assert property (@(posedge clk) disable iff (!rst_n) rx_irq |-> tx_en && frm_is_ack && frm_start); // R7
endmodule

bind ack_txn_seq ack_txn_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .syn_en(syn_en), .tx_en(tx_en),
  .rx_en(rx_en), .frm_start(frm_start), .frm_is_ack(frm_is_ack), .busy(busy),
  .done_ack(done_ack), .tmo_err(tmo_err), .settle_err(settle_err), .rx_irq(rx_irq)
);

// File: tb/ack_txn_seq_test.sv
module ack_txn_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {end_sel[11:10], ack_delay[9:2], crc_match[1], expect_ack[0]}
  localparam logic [11:0] VEC [NV] = '{
    {2'd0, 8'd3,   1'b1, 1'b1},
    {2'd1, 8'd0,   1'b1, 1'b1},
    {2'd2, 8'd10,  1'b1, 1'b1},
    {2'd3, 8'd11,  1'b1, 1'b0},
    {2'd1, 8'd4,   1'b0, 1'b0},
    {2'd2, 8'd200, 1'b1, 1'b0},
    {2'd3, 8'd2,   1'b1, 1'b1},
    {2'd0, 8'd7,   1'b1, 1'b1}
  };
  localparam int ACK_LIM = 10;

  logic clk = 0, rst_n = 0;
  logic tx_go = 0, rx_go = 0, osc_rdy = 1, syn_rdy = 1, frm_done = 0;
  logic pkt_valid = 0, ack_seen = 0;
  logic [1:0]  end_sel = 0;
  logic [15:0] settle_limit = 16'd20, ack_limit = 16'(ACK_LIM);
  logic [15:0] tx_crc = 0, pkt_crc = 0, ack_crc = 0, ack_crc_out;
  logic osc_en, syn_en, tx_en, rx_en, frm_start, frm_is_ack, busy;
  logic done_ack, tmo_err, settle_err, rx_irq;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ack_txn_seq uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_end(input logic [1:0] sel, input string req);
    logic [3:0] exp_p, act_p;
    exp_p = (sel == 0) ? 4'b0000 : (sel == 1) ? 4'b1000 : (sel == 2) ? 4'b1100 : 4'b1111;
    act_p = {osc_en, syn_en, rx_en, busy};
    check(act_p == exp_p && !tx_en, req, act_p, exp_p);
  endtask

  task automatic leave_rx(input logic [1:0] sel);
    end_sel = sel;
    pkt_valid = 1; pkt_crc = 16'h5A5A;
    @(negedge clk); pkt_valid = 0; frm_done = 1;
    @(negedge clk); frm_done = 0;
  endtask

  task automatic run_tx(input int idx);
    logic [1:0] sel; int dly; bit match, exp_ok; int seen_i; bit seen_ok;
    sel = VEC[idx][11:10]; dly = int'(VEC[idx][9:2]);
    match = VEC[idx][1]; exp_ok = VEC[idx][0];
    end_sel = sel; tx_crc = 16'h1000 + 16'(idx);
    tx_go = 1; @(negedge clk); tx_go = 0;
    repeat (2) @(negedge clk);
    check(tx_en && frm_start && !frm_is_ack, "R2", {tx_en, frm_start, frm_is_ack}, 3'b110);
    frm_done = 1; @(negedge clk); frm_done = 0;
    check(rx_en, "R4", rx_en, 1);
    seen_i = -1; seen_ok = 0;
    for (int i = 0; i <= ACK_LIM + 2; i++) begin
      if (done_ack || tmo_err) begin seen_i = i; seen_ok = done_ack; break; end
      ack_seen = (i == dly);
      ack_crc = match ? tx_crc : (tx_crc ^ 16'h0001);
      @(negedge clk);
    end
    ack_seen = 0;
    if (exp_ok) check(seen_ok && seen_i == dly + 1, "R4", seen_i, dly + 1);
    else        check(!seen_ok && seen_i == ACK_LIM + 1, "R5", seen_i, ACK_LIM + 1);
    check_end(sel, "R6");
    if (sel == 3) leave_rx(2'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check({osc_en, syn_en, tx_en, rx_en, frm_start, busy, done_ack, tmo_err, settle_err, rx_irq} == 0,
          "R1", {osc_en, syn_en, tx_en, rx_en, busy}, 0);
    rst_n = 1; @(negedge clk);
    check(!osc_en && !busy, "R1", {osc_en, busy}, 0);

    for (int v = 0; v < NV; v++) run_tx(v);

    // R3: oscillator never ready
    end_sel = 2; settle_limit = 16'd4; osc_rdy = 0;
    tx_go = 1; @(negedge clk); tx_go = 0;
    repeat (4) @(negedge clk);
    check(!settle_err && osc_en, "R3", {settle_err, osc_en}, 2'b01);
    @(negedge clk);
    check(settle_err && !osc_en && !syn_en, "R3", {settle_err, osc_en}, 2'b10);
    @(negedge clk);
    check(!settle_err && !frm_start, "R3", settle_err, 0);
    osc_rdy = 1;

    // R2: synthesizer gating
    settle_limit = 16'd50; syn_rdy = 0; end_sel = 1;
    tx_go = 1; @(negedge clk); tx_go = 0;
    repeat (4) @(negedge clk);
    check(syn_en && !tx_en, "R2", {syn_en, tx_en}, 2'b10);
    syn_rdy = 1; @(negedge clk);
    check(tx_en && frm_start, "R2", {tx_en, frm_start}, 2'b11);
    @(negedge clk);
    check(tx_en && !frm_start, "R2", {tx_en, frm_start}, 2'b10);
    frm_done = 1; @(negedge clk); frm_done = 0;
    repeat (ACK_LIM + 2) @(negedge clk);
    check_end(2'd1, "R6");

    // R7, R8, R9: receive transaction
    end_sel = 3;
    rx_go = 1; @(negedge clk); rx_go = 0;
    repeat (2) @(negedge clk);
    check(rx_en && !tx_en && busy, "R7", {rx_en, tx_en}, 2'b10);
    tx_go = 1; @(negedge clk); tx_go = 0;
    @(negedge clk);
    check(rx_en && !tx_en && !frm_start, "R9", {rx_en, tx_en}, 2'b10);
    pkt_valid = 1; pkt_crc = 16'hABCD; @(negedge clk); pkt_valid = 0; pkt_crc = 0;
    check(rx_irq && tx_en && frm_is_ack && frm_start, "R7", {rx_irq, tx_en, frm_is_ack, frm_start}, 4'hF);
    check(ack_crc_out == 16'hABCD, "R7", ack_crc_out, 16'hABCD);
    frm_done = 1; @(negedge clk); frm_done = 0;
    check(!rx_irq && rx_en && busy && !tx_en, "R8", {rx_en, busy}, 2'b11);
    leave_rx(2'd0);
    check_end(2'd0, "R8");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule